// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block takes one asynchronous serial line and recovers characters from it. A clock-enable tick, made by a divider outside the block at sixteen times the bit rate, paces all sampling. The line first passes through a two-flop synchronizer. While the receiver is idle, it treats any low sample as a possible start edge. It then confirms the start bit from three samples taken near the middle of the bit. A short glitch is dropped, and the receiver goes straight back to hunting for an edge.

Each data bit and the single stop bit are decided in the same way, by a two-of-three vote over the middle samples. Data bits arrive least significant first. When the stop bit has been decided, the character moves into a holding register. A receive-complete flag is then set, and it can drive an interrupt request. A low stop bit marks a framing error, and the data is still delivered. If a character completes while the previous one is unread, an overrun flag is set. Reading the data clears both the receive-complete flag and the overrun flag. A parameter selects eight or nine data bits. The ninth bit has an output of its own.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset the receiver is idle with the line taken as high, and data_o, bit9_o, rc_flag_o, ferr_o, ovr_o and irq_o are all 0.
- R2: The line is examined only in cycles where tick_i is 1. A low level with no ticks starts nothing. In idle, the first ticked low sample is sample 1 of a start bit, and sample k of any later bit is sample 16*b+k counted from that point.
- R3: A start bit is accepted when at least two of its samples 8, 9 and 10 are low. When two or more are high, the start is rejected with no flag change, and edge hunting resumes at the next tick.
- R4: Each data bit takes the majority value of its samples 8, 9 and 10, and all other samples have no effect. The first data bit received is bit 0 of the character.
- R5: When the stop bit is decided at its sample 10, the character is copied to data_o (with bit 8 on bit9_o) and rc_flag_o is set to 1. data_o changes at no other time.
- R6: ferr_o is loaded with 1 when the stop bit's majority value is 0, and with 0 when it is 1. The data is delivered in both cases.
- R7: After the stop-bit decision the receiver is idle, so a start edge at sample 11 of the stop bit begins a new character that is received correctly.
- R8: A character that completes while rc_flag_o is 1 and rd_i is 0 sets ovr_o to 1, and its data replaces the held data.
- R9: A cycle with rd_i = 1 clears ovr_o and clears rc_flag_o, unless a character completes in that same cycle, in which case rc_flag_o stays 1.
- R10: irq_o is 1 exactly when rc_flag_o is 1 and irq_en_i is 1.
- R11: With DATA_BITS = 9 the ninth received bit appears on bit9_o. With DATA_BITS = 8, bit9_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample enable at 16 times the bit rate |
| rxd_i | input | 1 | Serial line, asynchronous |
| rd_i | input | 1 | Data-read strobe; clears the receive-complete and overrun flags |
| irq_en_i | input | 1 | Interrupt enable for the receive-complete flag |
| data_o | output | 8 | Held character, bits 7..0 |
| bit9_o | output | 1 | Held ninth data bit (0 in eight-bit mode) |
| rc_flag_o | output | 1 | Receive-complete flag |
| ferr_o | output | 1 | Framing error of the held character |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench sweeps all 256 eight-bit characters and runs several nine-bit characters through a second instance. It aims at the vote boundaries. A single high start sample among 8 to 10 must still be accepted, while two high samples must cause a rejection. A design that used a single mid-bit sample, or that counted from the wrong sample, would instead lose characters or accept glitches. Disturbances placed on samples 7 and 11, and on one of the three voted samples, must leave the data unchanged. Disturbing two of the voted samples must flip exactly one bit, which exposes off-by-one sample placement or the wrong bit order.

The bench also sends a character back to back, with its start edge at stop-bit sample 11. A receiver that returned to idle only at the end of the stop bit would corrupt that character. Further tests cover a low stop bit, unread back-to-back characters and ticks held off with the line low. These expose designs that drop data on a framing error, fail to flag overrun, or sample without a tick.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_vote_rx_sync.sv
module uart_vote_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_vote_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_vote_rx_sampler.sv
module uart_vote_rx_sampler
   import uart_vote_rx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic rx_i,
   input  logic busy_i,
   output logic vote_valid_o,
   output logic vote_o
);
   localparam int MID = OSR / 2;
   localparam int CW  = $clog2(OSR + 1);

   generate
      if (OSR < 4) begin : g_bad_osr
         $error("uart_vote_rx_sampler: OSR must be at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] nxt;
   logic          first_q, second_q;

   // number of the sample being taken at this tick
   assign nxt = (cnt_q == CW'(OSR)) ? CW'(1) : cnt_q + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= CW'(1);
         first_q  <= 1'b1;
         second_q <= 1'b1;
      end else if (tick_i) begin
         if (!busy_i) begin
            cnt_q <= CW'(1);
         end else begin
            cnt_q <= nxt;
            if (nxt == CW'(MID))     first_q  <= rx_i;
            if (nxt == CW'(MID + 1)) second_q <= rx_i;
         end
      end
   end

   assign vote_valid_o = tick_i && busy_i && (nxt == CW'(MID + 2));
   assign vote_o       = maj3(first_q, second_q, rx_i);
endmodule

// File: rtl/uart_vote_rx_frame.sv
module uart_vote_rx_frame
   import uart_vote_rx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 rx_i,
   input  logic                 vote_valid_i,
   input  logic                 vote_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 stop_bit_o,
   output logic [DATA_BITS-1:0] word_o,
   output rx_state_e            state_o
);
   localparam int IW   = $clog2(DATA_BITS);
   localparam int LAST = DATA_BITS - 1;

   rx_state_e            state_q;
   logic [IW-1:0]        idx_q;
   logic [DATA_BITS-1:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         shreg_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (tick_i && !rx_i) state_q <= ST_START;
            end
            ST_START: begin
               if (vote_valid_i) begin
                  if (vote_i) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_DATA;
                     idx_q   <= '0;
                  end
               end
            end
            ST_DATA: begin
               if (vote_valid_i) begin
                  shreg_q <= {vote_i, shreg_q[DATA_BITS-1:1]};
                  if (idx_q == IW'(LAST)) state_q <= ST_STOP;
                  else                    idx_q   <= idx_q + IW'(1);
               end
            end
            ST_STOP: begin
               if (vote_valid_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = vote_valid_i && (state_q == ST_STOP);
   assign stop_bit_o = vote_i;
   assign word_o     = shreg_q;
   assign state_o    = state_q;
endmodule

// File: rtl/uart_vote_rx_hold.sv
module uart_vote_rx_hold #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done_i,
   input  logic [DATA_BITS-1:0] word_i,
   input  logic                 stop_bit_i,
   input  logic                 rd_i,
   output logic [DATA_BITS-1:0] word_o,
   output logic                 rc_o,
   output logic                 ferr_o,
   output logic                 ovr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         rc_o   <= 1'b0;
         ferr_o <= 1'b0;
         ovr_o  <= 1'b0;
      end else begin
         if (done_i) begin
            word_o <= word_i;
            ferr_o <= ~stop_bit_i;
         end
         if (done_i)    rc_o <= 1'b1;
         else if (rd_i) rc_o <= 1'b0;
         if (rd_i)                   ovr_o <= 1'b0;
         else if (done_i && rc_o)    ovr_o <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
   import uart_vote_rx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       rxd_i,
   input  logic       rd_i,
   input  logic       irq_en_i,
   output logic [7:0] data_o,
   output logic       bit9_o,
   output logic       rc_flag_o,
   output logic       ferr_o,
   output logic       ovr_o,
   output logic       irq_o
);
   generate
      if (DATA_BITS != 8 && DATA_BITS != 9) begin : g_bad_width
         $error("uart_vote_rx: DATA_BITS must be 8 or 9");
      end
   endgenerate

   logic                 rx_s;
   logic                 frame_busy, frame_done, stop_bit;
   logic                 vote_valid, vote;
   logic [DATA_BITS-1:0] word, word_q;
   rx_state_e            frame_state;

   uart_vote_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rx_s)
   );

   uart_vote_rx_sampler #(.OSR(OSR)) sampler_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_s),
      .busy_i(frame_busy), .vote_valid_o(vote_valid), .vote_o(vote)
   );

   uart_vote_rx_frame #(.DATA_BITS(DATA_BITS)) frame_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_s),
      .vote_valid_i(vote_valid), .vote_i(vote),
      .busy_o(frame_busy), .done_o(frame_done), .stop_bit_o(stop_bit),
      .word_o(word), .state_o(frame_state)
   );

   uart_vote_rx_hold #(.DATA_BITS(DATA_BITS)) hold_i (
      .clk(clk), .rst_n(rst_n), .done_i(frame_done), .word_i(word),
      .stop_bit_i(stop_bit), .rd_i(rd_i), .word_o(word_q),
      .rc_o(rc_flag_o), .ferr_o(ferr_o), .ovr_o(ovr_o)
   );

   assign data_o = word_q[7:0];

   generate
      if (DATA_BITS == 9) begin : g_nine
         assign bit9_o = word_q[DATA_BITS-1];
      end else begin : g_eight
         assign bit9_o = 1'b0;
      end
   endgenerate

   assign irq_o = rc_flag_o & irq_en_i;
endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       rd_i,
   input logic       irq_en_i,
   input logic       done_i,
   input logic [1:0] state_i,
   input logic [7:0] data_i,
   input logic       ferr_i,
   input logic       ovr_i,
   input logic       rc_i,
   input logic       irq_i
);
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rc_i && !ovr_i && !ferr_i && data_i == 8'd0));

   a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(state_i));

   a_r5_done_sets_rc: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> rc_i);

   a_r5_data_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(data_i));

   a_r6_ferr_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(ferr_i));

   a_r8_ovr_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_i) |-> $past(rc_i));

   a_r9_read_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> !ovr_i);

   a_r9_read_clears_rc: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !done_i) |=> !rc_i);

   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |-> !irq_i);
endmodule

bind uart_vote_rx uart_vote_rx_chk chk_i (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rd_i(rd_i),
   .irq_en_i(irq_en_i), .done_i(frame_done), .state_i(frame_state),
   .data_i(data_o), .ferr_i(ferr_o), .ovr_i(ovr_o), .rc_i(rc_flag_o),
   .irq_i(irq_o)
);

// File: tb/uart_vote_rx_tb.sv
module uart_vote_rx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic rxd8 = 1'b1, rxd9 = 1'b1;
   logic rd8 = 1'b0, rd9 = 1'b0;
   logic irq_en = 1'b0;

   logic [7:0] d8, d9;
   logic b8, b9, rc8, rc9, fe8, fe9, ov8, ov9, iq8, iq9;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit finished = 0;

   logic smp [0:255];
   int   slen;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_vote_rx #(.DATA_BITS(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd8), .rd_i(rd8),
      .irq_en_i(irq_en), .data_o(d8), .bit9_o(b8), .rc_flag_o(rc8),
      .ferr_o(fe8), .ovr_o(ov8), .irq_o(iq8)
   );

   uart_vote_rx #(.DATA_BITS(9)) dut9_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd9), .rd_i(rd9),
      .irq_en_i(1'b0), .data_o(d9), .bit9_o(b9), .rc_flag_o(rc9),
      .ferr_o(fe9), .ovr_o(ov9), .irq_o(iq9)
   );

   function automatic int pk(bit o, bit f, bit r, bit n9, int d);
      return (int'(o) << 11) | (int'(f) << 10) | (int'(r) << 9) | (int'(n9) << 8) | (d & 255);
   endfunction

   function automatic int snap8();
      return pk(ov8, fe8, rc8, b8, int'(d8));
   endfunction

   function automatic int snap9();
      return pk(ov9, fe9, rc9, b9, int'(d9));
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      nchk++;
      if (got != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   // frame image: index 16*b + s - 1 is sample s of bit b (0 = start)
   task automatic build(input int val, input int nb, input bit stopv);
      for (int i = 0; i < 256; i++) smp[i] = 1'b1;
      for (int i = 0; i < 16; i++) smp[i] = 1'b0;
      for (int b = 0; b < nb; b++)
         for (int s = 0; s < 16; s++) smp[16*(b+1)+s] = 1'((val >> b) & 1);
      for (int s = 0; s < 10; s++) smp[16*(nb+1)+s] = stopv;
      slen = 16 * (nb + 2);
   endtask

   task automatic play(input bit nine, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b0;
         if (nine) rxd9 = smp[i]; else rxd8 = smp[i];
         @(negedge clk);
         tick = 1'b1;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b0;
         rxd8 = 1'b1;
         rxd9 = 1'b1;
         @(negedge clk);
         tick = 1'b1;
      end
   endtask

   task automatic rd_pulse(input bit nine);
      @(negedge clk);
      if (nine) rd9 = 1'b1; else rd8 = 1'b1;
      @(negedge clk);
      rd8 = 1'b0;
      rd9 = 1'b0;
   endtask

   task automatic send8(input int val);
      build(val, 8, 1'b1);
      play(1'b0, slen);
      idle(3);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !finished) begin
         finished = 1;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 reset dut8", snap8(), 0);
      chk("R1 reset dut9", snap9(), 0);
      chk("R1 irq", int'(iq8), 0);

      // R2 low line with no ticks starts nothing
      tick = 1'b0;
      rxd8 = 1'b0;
      repeat (40) @(negedge clk);
      rxd8 = 1'b1;
      idle(40);
      chk("R2 no tick no start", snap8(), 0);

      // R4 R5 R11 full sweep of eight-bit characters
      for (int v = 0; v < 256; v++) begin
         send8(v);
         chk("R4 R5 sweep", snap8(), pk(0, 0, 1, 0, v));
         rd_pulse(1'b0);
         chk("R9 read clears rc", int'(rc8), 0);
      end

      // R3 rejection: samples 9 and 10 high
      for (int i = 0; i < 256; i++) smp[i] = 1'b1;
      for (int i = 0; i < 16; i++) smp[i] = 1'b0;
      smp[8] = 1'b1;
      smp[9] = 1'b1;
      play(1'b0, 40);
      idle(20);
      chk("R3 two high rejects", int'(rc8), 0);

      // R3 rejection: single low sample
      for (int i = 0; i < 256; i++) smp[i] = 1'b1;
      smp[0] = 1'b0;
      play(1'b0, 40);
      idle(20);
      chk("R3 glitch rejects", int'(rc8), 0);

      // R3 acceptance with sample 8 high
      build(8'h5A, 8, 1'b1);
      smp[7] = 1'b1;
      play(1'b0, slen);
      idle(3);
      chk("R3 one high accepts", snap8(), pk(0, 0, 1, 0, 8'h5A));
      rd_pulse(1'b0);

      // R4 two of three flipped on data bit 2
      build(8'h3C, 8, 1'b1);
      smp[16*3+7] = 1'b0;
      smp[16*3+8] = 1'b0;
      play(1'b0, slen);
      idle(3);
      chk("R4 two flipped", snap8(), pk(0, 0, 1, 0, 8'h38));
      rd_pulse(1'b0);

      // R4 one of three flipped on data bit 5
      build(8'h3C, 8, 1'b1);
      smp[16*6+8] = 1'b0;
      play(1'b0, slen);
      idle(3);
      chk("R4 one flipped", snap8(), pk(0, 0, 1, 0, 8'h3C));
      rd_pulse(1'b0);

      // R4 samples 7 and 11 of bit 0 ignored
      build(8'h3C, 8, 1'b1);
      smp[16*1+6]  = 1'b1;
      smp[16*1+10] = 1'b1;
      play(1'b0, slen);
      idle(3);
      chk("R4 outer samples ignored", snap8(), pk(0, 0, 1, 0, 8'h3C));
      rd_pulse(1'b0);

      // R6 framing error keeps data
      build(8'hA5, 8, 1'b0);
      play(1'b0, slen);
      idle(3);
      chk("R6 ferr set", snap8(), pk(0, 1, 1, 0, 8'hA5));
      rd_pulse(1'b0);
      send8(8'h3C);
      chk("R6 ferr cleared", snap8(), pk(0, 0, 1, 0, 8'h3C));
      rd_pulse(1'b0);

      // R8 overrun
      send8(8'h11);
      send8(8'h22);
      chk("R8 overrun", snap8(), pk(1, 0, 1, 0, 8'h22));
      rd_pulse(1'b0);
      chk("R9 read clears ovr", snap8(), pk(0, 0, 0, 0, 8'h22));

      // R7 start edge at stop sample 11
      build(8'h81, 8, 1'b1);
      play(1'b0, 16*9 + 10);
      build(8'h7E, 8, 1'b1);
      play(1'b0, slen);
      idle(3);
      chk("R7 early restart", snap8(), pk(1, 0, 1, 0, 8'h7E));
      rd_pulse(1'b0);

      // R10 interrupt gating
      send8(8'h42);
      chk("R10 irq off", int'(iq8), 0);
      @(negedge clk);
      irq_en = 1'b1;
      @(negedge clk);
      chk("R10 irq on", int'(iq8), 1);
      rd_pulse(1'b0);
      chk("R10 irq after read", int'(iq8), 0);
      irq_en = 1'b0;

      // R11 nine-bit characters
      begin
         int vals [4] = '{9'h1A5, 9'h0A5, 9'h100, 9'h0FF};
         foreach (vals[k]) begin
            build(vals[k], 9, 1'b1);
            play(1'b1, slen);
            idle(3);
            chk("R11 nine bit", snap9(), pk(0, 0, 1, 1'((vals[k] >> 8) & 1), vals[k] & 255));
            rd_pulse(1'b1);
         end
      end
      chk("R11 eight bit bit9 low", int'(b8), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule